// File: doc/BRIEF.md
# Dual 8-bit Countdown Timer Pair

This block contains two independent 8-bit down-counters driven by one system clock. The first counter (timer A) runs from an internal prescaler that divides the clock by 4 or by 1024. It counts a loaded value down to zero, raises its flag, and then stops. It stays stopped until software loads it again.

The second counter (timer B) keeps a preset value and reloads it automatically each time it expires, so it produces a periodic flag. It is clocked either by its own internal prescaler (divide by 4 or by 1024) or by rising edges on an external event pin. The event pin passes through a two-flop synchronizer and a rising-edge detector before it reaches the counter.

Software uses a write strobe with an address and data byte, and a separate combinational read port. Both underflow flags are sticky and drive the two interrupt request outputs directly.

Timer A is controlled by a two-state machine:
- IDLE goes to RUN when a nonzero value is loaded.
- RUN goes to IDLE on the final tick, or when zero is loaded.

Timer B is controlled by a two-state machine:
- HALT goes to RUN on the first preset write.
- RUN then stays in RUN.

Top module: `dual_timer_pair`

## Requirements
- R1: After reset, both counts, the control byte and the status byte read 0, and irq0 and irq1 are low.
- R2: Writing a nonzero value v to address 0 sets timer A's count to v. With control bit 0 clear, the count falls by one every 4 clocks. It reaches 0, and status bit 0 sets, exactly 4·v clock edges after the write edge.
- R3: With control bit 0 set, timer A's prescaler divides by 1024, so a load of v expires 1024·v edges after the write.
- R4: Once timer A reaches 0 it holds at 0 and raises no further flag until it is written again. Writing 0 to address 0 leaves it stopped and sets no flag.
- R5: A write to a timer's load address restarts that timer's prescaler phase. Expiry timing is counted from the latest write, whatever the prescaler phase was before it.
- R6: Writing v to address 1 sets timer B's preset and count to v. On a tick where the count is 1 (or 0), the count reloads to the preset and status bit 1 sets. Otherwise each tick lowers the count by one.
- R7: Timer B uses its internal prescaler when control bit 1 is clear. Control bit 2 selects divide by 1024 (set) or divide by 4 (clear).
- R8: With control bit 1 set, timer B ticks once per rising edge of evt_in, on the third clock edge after the pin rises. A pin held high counts only once.
- R9: Status flags are sticky. Writing address 3 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. An underflow in the same cycle as a clear leaves the flag set.
- R10: The read port is combinational by rd_addr:
  - address 0 returns timer A's count;
  - address 1 returns timer B's count;
  - address 2 returns {5'b0, control[2:0]};
  - address 3 returns {6'b0, flag1, flag0}.
- R11: irq0 equals status bit 0, and irq1 equals status bit 1, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 timer A load, 1 timer B preset, 2 control, 3 status clear |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| evt_in | input | 1 | Asynchronous external event pin for timer B |
| irq0 | output | 1 | Timer A underflow request |
| irq1 | output | 1 | Timer B underflow request |

## Verification
A wrong count or a prescaler phase error moves the edge where irq0 or irq1 rises. The bench predicts that edge from the write edge and compares it exactly. A timer A state machine stuck in RUN shows up as a count read that keeps changing after zero, or as a second unexpected request. A bad reload value shows on the next count read after timer B expires. A synchronizer with the wrong depth shifts the event-driven expiry by whole cycles. Most faults therefore appear within one prescaler period of the point where they occur.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

    typedef enum logic [1:0] {
        ADDR_T0   = 2'd0,
        ADDR_T1   = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_STAT = 2'd3
    } reg_addr_e;

    typedef enum logic {
        T0_IDLE = 1'b0,
        T0_RUN  = 1'b1
    } t0_state_e;

    typedef enum logic {
        T1_HALT = 1'b0,
        T1_RUN  = 1'b1
    } t1_state_e;

    typedef struct packed {
        logic t1_div_slow;
        logic t1_evt_src;
        logic t0_div_slow;
    } ctrl_t;

    localparam int CTRL_W = 3;
    localparam int FLAG_W = 2;

endpackage

// File: rtl/dtp_prescaler.sv
module dtp_prescaler #(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic slow_sel,
    output logic tick
);
    localparam int PW = $clog2(SLOW_DIV);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] limit;

    assign limit = slow_sel ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
    assign tick  = (phase_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/dtp_edge_sync.sv
module dtp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= pin;
            for (int i = 1; i <= STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/dtp_oneshot_timer.sv
module dtp_oneshot_timer import dtp_pkg::*; #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         running,
    output logic         underflow
);
    localparam logic [W-1:0] ONE = W'(1);

    t0_state_e state_q, state_d;
    logic      last_tick;

    assign last_tick = (state_q == T0_RUN) && !load && tick && (cnt == ONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T0_IDLE: if (load && (load_val != '0)) state_d = T0_RUN;
            T0_RUN: begin
                if (load && (load_val == '0)) state_d = T0_IDLE;
                else if (last_tick)           state_d = T0_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T0_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if ((state_q == T0_RUN) && tick) begin
            cnt <= cnt - ONE;
        end
    end

    always_comb begin
        running   = (state_q == T0_RUN);
        underflow = last_tick;
    end
endmodule

// File: rtl/dtp_reload_timer.sv
module dtp_reload_timer import dtp_pkg::*; #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic [W-1:0] preset,
    output logic         underflow
);
    localparam logic [W-1:0] ONE = W'(1);

    t1_state_e state_q, state_d;
    logic      expire;

    assign expire = (state_q == T1_RUN) && !load && tick && (cnt <= ONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T1_HALT: if (load) state_d = T1_RUN;
            T1_RUN:  state_d = T1_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T1_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            preset <= '0;
        end else if (load) begin
            cnt    <= load_val;
            preset <= load_val;
        end else if (expire) begin
            cnt    <= preset;
        end else if ((state_q == T1_RUN) && tick) begin
            cnt    <= cnt - ONE;
        end
    end

    always_comb begin
        underflow = expire;
    end
endmodule

// File: rtl/dual_timer_pair.sv
module dual_timer_pair import dtp_pkg::*; #(
    parameter int CNT_W       = 8,
    parameter int FAST_DIV    = 4,
    parameter int SLOW_DIV    = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             evt_in,
    output logic             irq0,
    output logic             irq1
);
    reg_addr_e waddr, raddr;
    logic      t0_load, t1_load, ctrl_wr, stat_wr;

    assign waddr   = reg_addr_e'(wr_addr);
    assign raddr   = reg_addr_e'(rd_addr);
    assign t0_load = wr_en && (waddr == ADDR_T0);
    assign t1_load = wr_en && (waddr == ADDR_T1);
    assign ctrl_wr = wr_en && (waddr == ADDR_CTRL);
    assign stat_wr = wr_en && (waddr == ADDR_STAT);

    ctrl_t             ctrl_q;
    logic [FLAG_W-1:0] flag_q;

    logic             tick0, tick1_int, evt_rise, tick1;
    logic [CNT_W-1:0] t0_count, t1_count, t1_preset;
    logic             t0_running, t0_uf, t1_uf;

    dtp_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_presc0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (t0_load),
        .slow_sel (ctrl_q.t0_div_slow),
        .tick     (tick0)
    );

    dtp_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_presc1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (t1_load),
        .slow_sel (ctrl_q.t1_div_slow),
        .tick     (tick1_int)
    );

    dtp_edge_sync #(.STAGES(SYNC_STAGES)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (evt_in),
        .rise  (evt_rise)
    );

    assign tick1 = ctrl_q.t1_evt_src ? evt_rise : tick1_int;

    dtp_oneshot_timer #(.W(CNT_W)) u_t0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (t0_load),
        .load_val  (wr_data),
        .tick      (tick0),
        .cnt       (t0_count),
        .running   (t0_running),
        .underflow (t0_uf)
    );

    dtp_reload_timer #(.W(CNT_W)) u_t1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (t1_load),
        .load_val  (wr_data),
        .tick      (tick1),
        .cnt       (t1_count),
        .preset    (t1_preset),
        .underflow (t1_uf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q[0] <= (flag_q[0] & ~(stat_wr & wr_data[0])) | t0_uf;
            flag_q[1] <= (flag_q[1] & ~(stat_wr & wr_data[1])) | t1_uf;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (raddr)
            ADDR_T0:   rd_data = t0_count;
            ADDR_T1:   rd_data = t1_count;
            ADDR_CTRL: rd_data = CNT_W'(ctrl_q);
            ADDR_STAT: rd_data = CNT_W'(flag_q);
        endcase
    end

    assign irq0 = flag_q[0];
    assign irq1 = flag_q[1];
endmodule

// File: rtl/dtp_checker.sv
module dtp_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic         irq0,
    input logic         irq1,
    input logic [W-1:0] t0_cnt,
    input logic         t0_run,
    input logic         t0_uf,
    input logic [W-1:0] t1_cnt,
    input logic [W-1:0] t1_preset,
    input logic         t1_uf
);
    logic t0_wr, clr0, clr1;
    assign t0_wr = wr_en && (wr_addr == 2'd0);
    assign clr0  = wr_en && (wr_addr == 2'd3) && wr_data[0];
    assign clr1  = wr_en && (wr_addr == 2'd3) && wr_data[1];

    assert_t0_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_run && !t0_wr) |=> (t0_cnt == $past(t0_cnt)) || (t0_cnt == $past(t0_cnt) - W'(1)));

    assert_t0_run_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        t0_run |-> (t0_cnt != '0));

    assert_t0_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!t0_run && !t0_wr) |=> $stable(t0_cnt));

    assert_t1_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        t1_uf |=> (t1_cnt == t1_preset));

    assert_flag0_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0 && !clr0) |=> irq0);

    assert_flag1_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq1 && !clr1) |=> irq1);

    assert_flag0_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && !t0_uf) |=> !irq0);

    assert_irq0_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        t0_uf |=> irq0);

    assert_irq1_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        t1_uf |=> irq1);
endmodule

bind dual_timer_pair dtp_checker #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq0      (irq0),
    .irq1      (irq1),
    .t0_cnt    (t0_count),
    .t0_run    (t0_running),
    .t0_uf     (t0_uf),
    .t1_cnt    (t1_count),
    .t1_preset (t1_preset),
    .t1_uf     (t1_uf)
);

// File: tb/tb_dual_timer_pair.sv
module tb_dual_timer_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       evt_in = 1'b0;
    logic       irq0, irq1;

    int  edge_n = 0;
    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    int  exp0[$];
    int  exp1[$];
    logic p0 = 1'b0, p1 = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    dual_timer_pair dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_in(evt_in), .irq0(irq0), .irq1(irq1)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: pops the expected edge of each request rise (R2 R3 R6 R8 R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq0 && !p0) begin
                if (exp0.size() == 0) chk(1'b0, "R2 unexpected irq0 edge", edge_n, -1);
                else begin
                    int e;
                    e = exp0.pop_front();
                    chk(edge_n == e, "R2 irq0 rise edge", edge_n, e);
                end
            end
            if (irq1 && !p1) begin
                if (exp1.size() == 0) chk(1'b0, "R6 unexpected irq1 edge", edge_n, -1);
                else begin
                    int e;
                    e = exp1.pop_front();
                    chk(edge_n == e, "R6 irq1 rise edge", edge_n, e);
                end
            end
        end
        p0 = irq0;
        p1 = irq1;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d, output int at);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        at = edge_n;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int expv, input string tag);
        rd_addr = a;
        #1;
        chk(int'(rd_data) == expv, tag, int'(rd_data), expv);
    endtask

    task automatic wait_to(input int t);
        while (edge_n < t) @(negedge clk);
    endtask

    task automatic pulse(input int high_cycles);
        @(negedge clk);
        evt_in = 1'b1;
        repeat (high_cycles) @(negedge clk);
        evt_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    end

    initial begin
        int w, w2, x;
        wait (rst_n == 1'b1);
        @(negedge clk);
        // R1 reset state
        rd_chk(2'd0, 0, "R1 t0 count");
        rd_chk(2'd1, 0, "R1 t1 count");
        rd_chk(2'd2, 0, "R1 control");
        @(negedge clk);
        rd_chk(2'd3, 0, "R1 status");
        chk(irq0 == 1'b0 && irq1 == 1'b0, "R1 irq low", {irq1, irq0}, 0);

        // R2 one-shot with divide by 4
        wr(2'd0, 8'd5, w);
        exp0.push_back(w + 20);
        wait_to(w + 8);
        rd_chk(2'd0, 3, "R2 mid count");
        wait_to(w + 20);
        rd_chk(2'd3, 1, "R10 status after t0 expiry");
        rd_chk(2'd0, 0, "R2 count at zero");
        chk(irq0 == 1'b1, "R11 irq0 follows flag", irq0, 1);

        // R4 stays at zero, no refire
        wait_to(w + 44);
        rd_chk(2'd0, 0, "R4 held at zero");
        wr(2'd3, 8'd1, x);
        rd_chk(2'd3, 0, "R9 clear flag0");
        chk(irq0 == 1'b0, "R11 irq0 low after clear", irq0, 0);
        wr(2'd0, 8'd0, x);
        wait_to(x + 30);
        rd_chk(2'd3, 0, "R4 zero load sets no flag");
        rd_chk(2'd0, 0, "R4 zero load stays stopped");

        // R5 prescaler phase restart on load
        wr(2'd0, 8'd10, w);
        wait_to(w + 2);
        wr(2'd0, 8'd3, w2);
        exp0.push_back(w2 + 12);
        wait_to(w2 + 11);
        rd_chk(2'd0, 1, "R5 count timed from latest write");
        wait_to(w2 + 12);
        wr(2'd3, 8'd1, x);

        // R3 divide by 1024
        wr(2'd2, 8'd1, x);
        rd_chk(2'd2, 1, "R10 control readback");
        wr(2'd0, 8'd2, w);
        exp0.push_back(w + 2048);
        wait_to(w + 1024);
        rd_chk(2'd0, 1, "R3 slow prescale mid count");
        wait_to(w + 2048);
        rd_chk(2'd3, 1, "R3 slow expiry flag");
        wr(2'd3, 8'd1, x);

        // R9 set wins over simultaneous clear
        wr(2'd2, 8'd0, x);
        wr(2'd0, 8'd1, w);
        exp0.push_back(w + 4);
        wait_to(w + 2);
        wr(2'd3, 8'd1, x);
        chk(x == w + 4, "R9 clear aligned with underflow", x, w + 4);
        rd_chk(2'd3, 1, "R9 set wins over clear");
        wr(2'd3, 8'd1, x);

        // R6 auto reload, internal divide by 4
        wr(2'd1, 8'd3, w);
        exp1.push_back(w + 12);
        wait_to(w + 12);
        rd_chk(2'd1, 3, "R6 reloaded to preset");
        wait_to(w + 16);
        rd_chk(2'd1, 2, "R6 counting after reload");
        wr(2'd3, 8'd1, x);
        rd_chk(2'd3, 2, "R9 zero bit leaves flag1");
        wr(2'd3, 8'd2, x);
        exp1.push_back(w + 24);
        wait_to(w + 24);
        rd_chk(2'd3, 2, "R6 second period flag");
        wr(2'd3, 8'd2, x);

        // R7 internal divide by 1024 for timer B
        wr(2'd2, 8'd4, x);
        wr(2'd1, 8'd1, w);
        exp1.push_back(w + 1024);
        wait_to(w + 1023);
        rd_chk(2'd3, 0, "R7 no flag before 1024");
        wait_to(w + 1024);
        rd_chk(2'd3, 2, "R7 slow prescale flag");
        wr(2'd3, 8'd2, x);

        // R8 event counting
        wr(2'd2, 8'd2, x);
        wr(2'd1, 8'd3, w);
        pulse(2);
        rd_chk(2'd1, 2, "R8 first event");
        pulse(2);
        rd_chk(2'd1, 1, "R8 second event");
        exp1.push_back(edge_n + 1 + 3);
        pulse(2);
        rd_chk(2'd1, 3, "R8 expiry reloads");
        rd_chk(2'd3, 2, "R8 event expiry flag");
        pulse(20);
        rd_chk(2'd1, 2, "R8 held level counts once");

        repeat (10) @(negedge clk);
        chk(exp0.size() == 0, "R2 pending irq0 expectations", exp0.size(), 0);
        chk(exp1.size() == 0, "R6 pending irq1 expectations", exp1.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", edge_n, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule